// File: doc/BRIEF.md
# Serial Identifier Isolation Responder

This block lets one card take part in a plug-and-play isolation contest on a shared data bus. The card holds a 72-bit serial identifier. The identifier is made of a 32-bit vendor field, a 32-bit serial field and an 8-bit checksum. The checksum is supplied as a constant input. After a restart, host software reads the isolation register twice for each identifier bit. On a one bit the card places a fixed two-byte pattern on the bus. On a zero bit it stays off the bus and watches it. If it sees another card's pattern, it withdraws.

The data bus acts as a wired contest. Only a card whose identifier has a one where the others have a zero survives each bit. A card that gets through all 72 bits without withdrawing raises its win flag. A card that withdraws raises its loss flag and stays quiet. Both flags hold until the next restart.

Top module: `sid_contest`

## Requirements
- R1: After reset, won, lost and drive_en are low, and read strobes produce no drive and no change of won or lost until a restart is seen.
- R2: Identifier bit k is vendor_id[k] for k in 0..31, serial_id[k-32] for k in 32..63 and id_check[k-64] for k in 64..71. Bits are contested in increasing k, starting at k = 0 after a restart.
- R3: Each identifier bit takes exactly two read strobes. For a one bit, drive_en is high during the strobe itself, with drive_data 0x55 on the first read and 0xAA on the second.
- R4: For a zero bit, drive_en stays low on both reads. Whenever drive_en is low, drive_data is 0x00.
- R5: If a zero-bit card samples 0x55 on the first read and then 0xAA on the second read, lost goes high in the cycle after that second strobe. After that no further strobe produces drive.
- R6: A zero-bit card that samples any other pair of bytes (for example 0x55 then 0x00, or 0x00 then 0xAA) keeps contesting with the next bit.
- R7: After the 144th strobe since a restart with no loss, won goes high in the following cycle. After that, strobes produce no drive.
- R8: A restart pulse (iso_enter) clears won and lost and sends the next strobe to bit 0 on its first read, even in the middle of a contest. A restart has priority over a strobe in the same cycle.
- R9: won and lost are never high together, and each holds its value until the next restart.
- R10: A one-bit card ignores the sampled bus and cannot lose on that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iso_enter | input | 1 | One-cycle pulse: wake with select number zero, restart the contest |
| rd_strobe | input | 1 | One-cycle read of the isolation register, qualified by isolation state |
| bus_in | input | 8 | Data bus as sampled during the strobe |
| vendor_id | input | 32 | Vendor field of the identifier (constant) |
| serial_id | input | 32 | Serial field of the identifier (constant) |
| id_check | input | 8 | Checksum byte of the identifier (constant) |
| drive_en | output | 1 | Tri-state enable for the data bus |
| drive_data | output | 8 | Byte to place on the bus when enabled |
| won | output | 1 | All identifier bits survived |
| lost | output | 1 | Withdrew, back to sleep |

## Verification
Several properties are checked on every cycle. Drive only ever happens inside a strobe, and only with one of the two pattern bytes. The bus byte is zero whenever drive is off. The win and loss flags are exclusive and sticky until a restart. A loss can only begin right after a strobe, and a restart clears both flags. Some behaviour can only be shown by the bench's scenarios: the bit order across the three fields, the exact strobe at which a loss or a win occurs, and the fact that near-miss byte pairs do not cause withdrawal. The bench shows these by sweeping a loss onto every zero bit of the identifier and by running full contests.

// File: rtl/sid_pkg.sv
package sid_pkg;
    typedef enum logic {
        RD_FIRST  = 1'b0,
        RD_SECOND = 1'b1
    } rd_phase_e;
endpackage

// File: rtl/sid_bit_mux.sv
module sid_bit_mux #(
    parameter int FIELD_W = 32,
    parameter int CHK_W   = 8,
    localparam int ID_W   = 2 * FIELD_W + CHK_W,
    localparam int IDX_W  = $clog2(ID_W),
    localparam int PAD_W  = (1 << IDX_W) - ID_W
) (
    input  logic [FIELD_W-1:0] vendor_id,
    input  logic [FIELD_W-1:0] serial_id,
    input  logic [CHK_W-1:0]   id_check,
    input  logic [IDX_W-1:0]   bit_idx,
    output logic               cur_bit
);
    logic [ID_W-1:0]         full_id;
    logic [(1<<IDX_W)-1:0]   padded_id;

    // Vendor occupies the low bits so that it is contested first.
    assign full_id = {id_check, serial_id, vendor_id};

    generate
        if (PAD_W > 0) begin : g_pad
            assign padded_id = {{PAD_W{1'b0}}, full_id};
        end else begin : g_nopad
            assign padded_id = full_id;
        end
    endgenerate

    assign cur_bit = padded_id[bit_idx];
endmodule

// File: rtl/sid_drive.sv
module sid_drive #(
    parameter int              DATA_W = 8,
    parameter logic [DATA_W-1:0] PAT_A = 8'h55,
    parameter logic [DATA_W-1:0] PAT_B = 8'hAA
) (
    input  logic              rd_strobe,
    input  logic              contesting,
    input  logic              cur_bit,
    input  sid_pkg::rd_phase_e phase,
    output logic              drive_en,
    output logic [DATA_W-1:0] drive_data
);
    always_comb begin
        drive_en   = rd_strobe && contesting && cur_bit;
        drive_data = '0;
        if (drive_en) begin
            drive_data = (phase == sid_pkg::RD_SECOND) ? PAT_B : PAT_A;
        end
    end
endmodule

// File: rtl/sid_contest.sv
module sid_contest #(
    parameter int                FIELD_W = 32,
    parameter int                CHK_W   = 8,
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] PAT_A   = 8'h55,
    parameter logic [DATA_W-1:0] PAT_B   = 8'hAA,
    localparam int               ID_W    = 2 * FIELD_W + CHK_W,
    localparam int               IDX_W   = $clog2(ID_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               iso_enter,
    input  logic               rd_strobe,
    input  logic [DATA_W-1:0]  bus_in,
    input  logic [FIELD_W-1:0] vendor_id,
    input  logic [FIELD_W-1:0] serial_id,
    input  logic [CHK_W-1:0]   id_check,
    output logic               drive_en,
    output logic [DATA_W-1:0]  drive_data,
    output logic               won,
    output logic               lost
);
    import sid_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_W - 1);

    typedef struct packed {
        logic             active;
        rd_phase_e        phase;
        logic             saw_first;
        logic             won;
        logic             lost;
        logic [IDX_W-1:0] idx;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    logic cur_bit;

    sid_bit_mux #(.FIELD_W(FIELD_W), .CHK_W(CHK_W)) u_mux (
        .vendor_id (vendor_id),
        .serial_id (serial_id),
        .id_check  (id_check),
        .bit_idx   (ctx_q.idx),
        .cur_bit   (cur_bit)
    );

    sid_drive #(.DATA_W(DATA_W), .PAT_A(PAT_A), .PAT_B(PAT_B)) u_drive (
        .rd_strobe  (rd_strobe && !iso_enter),
        .contesting (ctx_q.active),
        .cur_bit    (cur_bit),
        .phase      (ctx_q.phase),
        .drive_en   (drive_en),
        .drive_data (drive_data)
    );

    always_comb begin
        ctx_d = ctx_q;
        if (iso_enter) begin
            ctx_d.active    = 1'b1;
            ctx_d.phase     = RD_FIRST;
            ctx_d.saw_first = 1'b0;
            ctx_d.won       = 1'b0;
            ctx_d.lost      = 1'b0;
            ctx_d.idx       = '0;
        end else if (rd_strobe && ctx_q.active) begin
            if (ctx_q.phase == RD_FIRST) begin
                ctx_d.phase     = RD_SECOND;
                ctx_d.saw_first = !cur_bit && (bus_in == PAT_A);
            end else begin
                ctx_d.phase     = RD_FIRST;
                ctx_d.saw_first = 1'b0;
                if (!cur_bit && ctx_q.saw_first && (bus_in == PAT_B)) begin
                    ctx_d.lost   = 1'b1;
                    ctx_d.active = 1'b0;
                end else if (ctx_q.idx == LAST_IDX) begin
                    ctx_d.won    = 1'b1;
                    ctx_d.active = 1'b0;
                end else begin
                    ctx_d.idx = ctx_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign won  = ctx_q.won;
    assign lost = ctx_q.lost;
endmodule

// File: rtl/sid_contest_chk.sv
module sid_contest_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iso_enter,
    input logic              rd_strobe,
    input logic              drive_en,
    input logic [DATA_W-1:0] drive_data,
    input logic              won,
    input logic              lost
);
    assert_drive_in_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> rd_strobe);
    assert_drive_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (drive_data == 8'h55 || drive_data == 8'hAA));
    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (drive_data == '0));
    assert_loss_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> $past(rd_strobe));
    assert_quiet_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (won || lost) |-> !drive_en);
    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iso_enter |=> (!won && !lost));
    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(won && lost));
    assert_lost_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !iso_enter) |=> lost);
    assert_won_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (won && !iso_enter) |=> won);
endmodule

bind sid_contest sid_contest_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iso_enter  (iso_enter),
    .rd_strobe  (rd_strobe),
    .drive_en   (drive_en),
    .drive_data (drive_data),
    .won        (won),
    .lost       (lost)
);

// File: tb/tb_sid_contest.sv
module tb_sid_contest;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iso_enter = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [7:0]  bus_in = 8'h00;
    logic [31:0] vendor_id = 32'hA5C3_0F96;
    logic [31:0] serial_id = 32'h1234_8E71;
    logic [7:0]  id_check  = 8'h6B;
    logic        drive_en;
    logic [7:0]  drive_data;
    logic        won, lost;

    int n_vec = 0;
    int n_bad = 0;
    logic       s_en;
    logic [7:0] s_data;

    always #2 clk = ~clk;

    sid_contest dut (
        .clk(clk), .rst_n(rst_n), .iso_enter(iso_enter), .rd_strobe(rd_strobe),
        .bus_in(bus_in), .vendor_id(vendor_id), .serial_id(serial_id),
        .id_check(id_check), .drive_en(drive_en), .drive_data(drive_data),
        .won(won), .lost(lost)
    );

    function automatic logic id_bit(int k);
        if (k < 32)      return vendor_id[k];
        else if (k < 64) return serial_id[k-32];
        else             return id_check[k-64];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One read strobe: sample drive during the strobe, flags after the edge.
    task automatic rd(input logic [7:0] b);
        @(negedge clk);
        rd_strobe = 1'b1;
        bus_in    = b;
        #1;
        s_en   = drive_en;
        s_data = drive_data;
        @(posedge clk);
        #1;
        rd_strobe = 1'b0;
        bus_in    = 8'h00;
    endtask

    task automatic restart();
        @(negedge clk);
        iso_enter = 1'b1;
        @(posedge clk);
        #1;
        iso_enter = 1'b0;
        check("R8 won clear", {31'd0, won}, 32'd0);
        check("R8 lost clear", {31'd0, lost}, 32'd0);
    endtask

    // Contest bit k; zero bits see a near-miss pair unless kill is set.
    task automatic bit_pair(int k, logic kill);
        logic one;
        logic [7:0] b1, b2;
        one = id_bit(k);
        if (one)       begin b1 = 8'h55; b2 = 8'hAA; end
        else if (kill) begin b1 = 8'h55; b2 = 8'hAA; end
        else if (k % 2 == 0) begin b1 = 8'h55; b2 = 8'h00; end
        else           begin b1 = 8'h00; b2 = 8'hAA; end
        rd(b1);
        check("R2/R3/R4 first read en", {31'd0, s_en}, {31'd0, one});
        check("R3/R4 first read data", {24'd0, s_data}, one ? 32'h55 : 32'h00);
        rd(b2);
        check("R2/R3/R4 second read en", {31'd0, s_en}, {31'd0, one});
        check("R3/R4 second read data", {24'd0, s_data}, one ? 32'hAA : 32'h00);
    endtask

    initial begin : watchdog
        #800000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check("R1 won after reset", {31'd0, won}, 32'd0);
        check("R1 lost after reset", {31'd0, lost}, 32'd0);
        check("R1 drive after reset", {31'd0, drive_en}, 32'd0);
        rst_n = 1'b1;
        // R1: strobes before any restart do nothing.
        for (int i = 0; i < 4; i++) begin
            rd(8'h55);
            check("R1 no drive before restart", {31'd0, s_en}, 32'd0);
            check("R1 no flags before restart", {30'd0, won, lost}, 32'd0);
        end

        // R7/R6/R10: full contest without loss.
        restart();
        for (int k = 0; k < 72; k++) begin
            bit_pair(k, 1'b0);
            check("R6/R10 no loss", {31'd0, lost}, 32'd0);
            check("R7 win timing", {31'd0, won}, (k == 71) ? 32'd1 : 32'd0);
        end
        rd(8'h55);
        check("R7 no drive after win", {31'd0, s_en}, 32'd0);
        check("R9 won holds", {30'd0, won, lost}, 32'd2);

        // R5: loss injected at every zero bit.
        for (int z = 0; z < 72; z++) begin
            if (!id_bit(z)) begin
                restart();
                for (int k = 0; k < z; k++) begin
                    bit_pair(k, 1'b0);
                    check("R6 survive near miss", {31'd0, lost}, 32'd0);
                end
                bit_pair(z, 1'b1);
                check("R5 lost after pattern", {31'd0, lost}, 32'd1);
                check("R9 not won", {31'd0, won}, 32'd0);
                rd(8'h55);
                check("R5 no drive after loss", {31'd0, s_en}, 32'd0);
                check("R9 lost holds", {31'd0, lost}, 32'd1);
            end
        end

        // R8: restart mid-contest, then a fresh first bit 0.
        restart();
        for (int k = 0; k < 5; k++) bit_pair(k, 1'b0);
        rd(8'h00); // first read of bit 5
        restart();
        bit_pair(0, 1'b0);
        bit_pair(1, 1'b0);
        check("R8 contest resumed", {30'd0, won, lost}, 32'd0);

        // R8: restart and strobe in the same cycle; restart wins.
        @(negedge clk);
        iso_enter = 1'b1;
        rd_strobe = 1'b1;
        bus_in    = 8'h00;
        #1;
        check("R8 no drive with restart", {31'd0, drive_en}, 32'd0);
        @(posedge clk);
        #1;
        iso_enter = 1'b0;
        rd_strobe = 1'b0;
        bit_pair(0, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule